// File: doc/BRIEF.md
# Banked GPIO Output and Configuration Register File

This block is the register file of a general-purpose I/O controller with up to 255 lines. The lines are grouped into banks of 64. Each bank has three registers:

- an input view of the pads;
- a write-one-to-set port for the output latches;
- a write-one-to-clear port for the output latches.

Because of the set and clear ports, software can change any subset of lines without a read-modify-write. Each line also has its own configuration word. That word enables the output driver, inverts the line in both directions, selects open-drain drive, and can hand the pad over to another function. The block drives the pad output and output-enable vectors and reads a pad input vector that has already been filtered. Filtering and interrupt logic live in other blocks.

The bus side is a plain 64-bit request port with byte addresses. A write takes effect at the clock edge where it is presented. A read returns data one cycle later under a valid strobe, sequenced by a two-state machine:

- `ST_IDLE` moves to `ST_RESP` when a read is requested.
- `ST_RESP` stays in `ST_RESP` while back-to-back reads continue.
- `ST_RESP` returns to `ST_IDLE` when no read is requested.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output latch and every configuration field is zero: `pad_oe` and `pad_out` are all zero and every register reads zero.
- R2: A write to bank offset 0x08 sets the latch of each line whose data bit is 1. Data bits that are 0 leave their latches unchanged.
- R3: A write to bank offset 0x10 clears the latch of each line whose data bit is 1. Data bits that are 0 leave their latches unchanged.
- R4: A read of bank offset 0x08 returns the current output latches. A read of bank offset 0x10 returns zero.
- R5: Bank b occupies byte addresses b*0x1400 + offset. Bit j of a bank register belongs to line b*64+j.
- R6: The configuration word of line n is at 0x400 + 8*n. Its fields are: bit 0 output enable, bit 1 invert, bit 12 open-drain, bits 25:16 function select. Every other bit reads as zero.
- R7: A line in push-pull mode that GPIO owns drives `pad_out` = latch XOR invert, and `pad_oe` equals its output-enable bit.
- R8: A line in open-drain mode never drives `pad_out` high. It asserts `pad_oe` only when output enable is set and latch XOR invert is 0.
- R9: Bank offset 0x00 reads `pad_in` XOR invert for each line.
- R10: While a line's function select is nonzero, set and clear writes leave its latch unchanged, and its `pad_oe` and `pad_out` are 0.
- R11: Address 0x90 reads the line count in bits 7:0 and the base interrupt vector in bits 15:8. All other bits are zero.
- R12: Unmapped addresses read zero, and writes to them change no state.
- R13: `bus_rvalid` is high in the cycle after each read request and only then. Pad outputs reflect a write from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | NUM_LINES | Filtered pad inputs |
| pad_out | output | NUM_LINES | Pad output values |
| pad_oe | output | NUM_LINES | Pad output enables |

## Verification
Register writes update the latch and configuration flops at the accepting edge, and the pad vectors follow through combinational logic. The bench therefore samples pads at the falling edge that follows a write. Read data passes through one register and appears with `bus_rvalid` at the falling edge one cycle after the request. The bench samples both there, then confirms one cycle later that the strobe has dropped. Input-register reads capture `pad_in` at the request edge, so the bench changes `pad_in` only while no read is pending.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int BANK_BITS   = 64;
    localparam int BANK_STRIDE = 'h1400;
    localparam int OFF_RX      = 'h0;
    localparam int OFF_SET     = 'h8;
    localparam int OFF_CLR     = 'h10;
    localparam int OFF_CONST   = 'h90;
    localparam int OFF_CFG     = 'h400;
    localparam int CFG_OE      = 0;
    localparam int CFG_INV     = 1;
    localparam int CFG_OD      = 12;
    localparam int CFG_SEL_LO  = 16;
    localparam int SEL_W       = 10;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             od;
        logic             inv;
        logic             oe;
    } line_cfg_t;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_RX, ACC_SET, ACC_CLR, ACC_CONST, ACC_CFG
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE, ST_RESP
    } bus_state_t;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 16,
    localparam int NBANK    = (NUM_LINES + BANK_BITS - 1) / BANK_BITS,
    localparam int BW       = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int LW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [BW-1:0]     bank,
    output logic [LW-1:0]     line
);
    logic [31:0] a32;
    assign a32 = {{(32-ADDR_W){1'b0}}, addr};

    always_comb begin
        kind = ACC_NONE;
        bank = '0;
        line = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (a32 == 32'(b * BANK_STRIDE + OFF_RX)) begin
                kind = ACC_RX;
                bank = BW'(b);
            end
            if (a32 == 32'(b * BANK_STRIDE + OFF_SET)) begin
                kind = ACC_SET;
                bank = BW'(b);
            end
            if (a32 == 32'(b * BANK_STRIDE + OFF_CLR)) begin
                kind = ACC_CLR;
                bank = BW'(b);
            end
        end
        if (a32 == 32'(OFF_CONST)) begin
            kind = ACC_CONST;
        end
        if (a32 >= 32'(OFF_CFG) && a32 < 32'(OFF_CFG + 8 * NUM_LINES)
            && a32[2:0] == 3'b000) begin
            kind = ACC_CFG;
            line = LW'((a32 - 32'(OFF_CFG)) >> 3);
        end
    end
endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    localparam int NBANK    = (NUM_LINES + BANK_BITS - 1) / BANK_BITS,
    localparam int BW       = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int LW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  acc_kind_t                        kind,
    input  logic [BW-1:0]                    bank,
    input  logic [LW-1:0]                    line,
    input  logic [63:0]                      wdata,
    output line_cfg_t [NUM_LINES-1:0]        cfg,
    output logic [NUM_LINES-1:0]             latch
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int BK = i / BANK_BITS;
        localparam int BT = i % BANK_BITS;
        line_cfg_t cfg_q;
        logic      lat_q;
        logic      bank_hit;
        logic      owned;

        assign bank_hit = (bank == BW'(BK));
        assign owned    = (cfg_q.sel == '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
                lat_q <= 1'b0;
            end else if (wr_en) begin
                if (kind == ACC_CFG && line == LW'(i)) begin
                    cfg_q.sel <= wdata[CFG_SEL_LO +: SEL_W];
                    cfg_q.od  <= wdata[CFG_OD];
                    cfg_q.inv <= wdata[CFG_INV];
                    cfg_q.oe  <= wdata[CFG_OE];
                end
                if (kind == ACC_SET && bank_hit && owned && wdata[BT]) begin
                    lat_q <= 1'b1;
                end
                if (kind == ACC_CLR && bank_hit && owned && wdata[BT]) begin
                    lat_q <= 1'b0;
                end
            end
        end

        assign cfg[i]   = cfg_q;
        assign latch[i] = lat_q;
    end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 128
) (
    input  line_cfg_t [NUM_LINES-1:0] cfg,
    input  logic [NUM_LINES-1:0]      latch,
    input  logic [NUM_LINES-1:0]      pad_in,
    output logic [NUM_LINES-1:0]      pad_out,
    output logic [NUM_LINES-1:0]      pad_oe,
    output logic [NUM_LINES-1:0]      rx
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pad
        logic drive;
        logic owned;
        assign drive      = latch[i] ^ cfg[i].inv;
        assign owned      = (cfg[i].sel == '0);
        assign pad_oe[i]  = owned & cfg[i].oe & (cfg[i].od ? ~drive : 1'b1);
        assign pad_out[i] = owned & ~cfg[i].od & drive;
        assign rx[i]      = pad_in[i] ^ cfg[i].inv;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int         NUM_LINES = 128,
    parameter int         ADDR_W    = 16,
    parameter logic [7:0] VEC_BASE  = 8'h30,
    localparam int NBANK            = (NUM_LINES + BANK_BITS - 1) / BANK_BITS,
    localparam int BW               = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int LW               = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe
);
    acc_kind_t                 dec_kind;
    logic [BW-1:0]             dec_bank;
    logic [LW-1:0]             dec_line;
    line_cfg_t [NUM_LINES-1:0] line_cfg;
    logic [NUM_LINES-1:0]      line_latch;
    logic [NUM_LINES-1:0]      line_rx;
    logic                      rd_en;
    logic                      wr_en;
    logic [63:0]               rd_val;
    logic [63:0]               rdata_q;
    bus_state_t                state_q, state_d;

    assign rd_en = bus_req & ~bus_we;
    assign wr_en = bus_req & bus_we;

    gpio_bank_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .kind (dec_kind),
        .bank (dec_bank),
        .line (dec_line)
    );

    gpio_line_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .kind  (dec_kind),
        .bank  (dec_bank),
        .line  (dec_line),
        .wdata (bus_wdata),
        .cfg   (line_cfg),
        .latch (line_latch)
    );

    gpio_pad_drive #(.NUM_LINES(NUM_LINES)) u_pad (
        .cfg     (line_cfg),
        .latch   (line_latch),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .rx      (line_rx)
    );

    // Read data selection
    always_comb begin
        rd_val = '0;
        unique case (dec_kind)
            ACC_RX: begin
                for (int j = 0; j < BANK_BITS; j++) begin
                    if (int'(dec_bank) * BANK_BITS + j < NUM_LINES) begin
                        rd_val[j] = line_rx[int'(dec_bank) * BANK_BITS + j];
                    end
                end
            end
            ACC_SET: begin
                for (int j = 0; j < BANK_BITS; j++) begin
                    if (int'(dec_bank) * BANK_BITS + j < NUM_LINES) begin
                        rd_val[j] = line_latch[int'(dec_bank) * BANK_BITS + j];
                    end
                end
            end
            ACC_CFG: begin
                rd_val[CFG_OE]                 = line_cfg[dec_line].oe;
                rd_val[CFG_INV]                = line_cfg[dec_line].inv;
                rd_val[CFG_OD]                 = line_cfg[dec_line].od;
                rd_val[CFG_SEL_LO +: SEL_W]    = line_cfg[dec_line].sel;
            end
            ACC_CONST: begin
                rd_val[7:0]  = 8'(NUM_LINES);
                rd_val[15:8] = VEC_BASE;
            end
            default: rd_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_en) state_d = ST_RESP;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Read data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_val;
        end
    end

    // Outputs
    always_comb begin
        bus_rvalid = (state_q == ST_RESP);
        bus_rdata  = rdata_q;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 128
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_req,
    input logic                      bus_we,
    input logic                      bus_rvalid,
    input logic [NUM_LINES-1:0]      pad_out,
    input logic [NUM_LINES-1:0]      pad_oe,
    input line_cfg_t [NUM_LINES-1:0] cfg,
    input logic [NUM_LINES-1:0]      latch
);
    logic [NUM_LINES-1:0] od_mask;
    logic [NUM_LINES-1:0] foreign_mask;
    logic [NUM_LINES-1:0] off_mask;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            od_mask[i]      = cfg[i].od;
            foreign_mask[i] = |cfg[i].sel;
            off_mask[i]     = ~cfg[i].oe;
        end
    end

    a_r13_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    a_r13_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    a_r8_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & od_mask) == '0);

    a_r10_foreign_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out) & foreign_mask) == '0);

    a_r7_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & off_mask) == '0);

    a_r2_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we) |=> $stable(latch));
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .cfg        (line_cfg),
    .latch      (line_latch)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int N = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          bus_rvalid;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    gpio_bank #(.NUM_LINES(N), .ADDR_W(16), .VEC_BASE(8'h30)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic        is_wr;
        logic [15:0] addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0408, 64'h1,  64'h0, 4'd6},           // R6 line 1 output enable
        '{1'b1, 16'h0008, 64'h6,  64'h0, 4'd2},           // R2 set lines 1,2
        '{1'b0, 16'h0008, 64'h0,  64'h6, 4'd4},           // R4 latch readback
        '{1'b1, 16'h0010, 64'h4,  64'h0, 4'd3},           // R3 clear line 2
        '{1'b0, 16'h0008, 64'h0,  64'h2, 4'd3},           // R3
        '{1'b1, 16'h0008, 64'h0,  64'h0, 4'd2},           // R2 zero bits no effect
        '{1'b0, 16'h0008, 64'h0,  64'h2, 4'd2},           // R2
        '{1'b1, 16'h1408, 64'h1,  64'h0, 4'd5},           // R5 set line 64
        '{1'b0, 16'h1408, 64'h0,  64'h1, 4'd5},           // R5
        '{1'b0, 16'h1410, 64'h0,  64'h0, 4'd4},           // R4 clear reg reads 0
        '{1'b1, 16'h0400, '1,     64'h0, 4'd6},           // R6 all ones
        '{1'b0, 16'h0400, 64'h0,  64'h0000_0000_03FF_1003, 4'd6}, // R6 mask
        '{1'b1, 16'h0400, 64'h0,  64'h0, 4'd6},           // R6 restore
        '{1'b0, 16'h0090, 64'h0,  64'h3080, 4'd11},       // R11 constants
        '{1'b0, 16'h2000, 64'h0,  64'h0, 4'd12},          // R12 unmapped
        '{1'b0, 16'h0018, 64'h0,  64'h0, 4'd12},          // R12 unmapped
        '{1'b1, 16'h2008, '1,     64'h0, 4'd12},          // R12 write ignored
        '{1'b0, 16'h0008, 64'h0,  64'h2, 4'd12}           // R12 latch unchanged
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [63:0] d, output logic v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_req = 1'b0;
    endtask

    initial begin
        #(10 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic        v;
        logic [127:0] pin;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 rvalid idle", bus_rvalid, 0);
        rst_n = 1'b1;
        bus_read(16'h0008, rd, v);  check("R1 latch bank0", rd, 0);
        check("R13 rvalid on read", v, 1);
        @(negedge clk); check("R13 rvalid drops", bus_rvalid, 0);
        bus_read(16'h1408, rd, v);  check("R1 latch bank1", rd, 0);
        bus_read(16'h0410, rd, v);  check("R1 cfg line2", rd, 0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].is_wr) begin
                bus_write(VEC[k].addr, VEC[k].data);
            end else begin
                bus_read(VEC[k].addr, rd, v);
                check($sformatf("R%0d vec %0d", VEC[k].req, k), rd, VEC[k].exp);
                check($sformatf("R13 vec %0d rvalid", k), v, 1);
            end
        end

        // R7 push-pull: line1 OE latch1, line64 latch1 OE off
        check("R7 line1 out", pad_out[1], 1);
        check("R7 line1 oe", pad_oe[1], 1);
        check("R7 line64 oe off", pad_oe[64], 0);
        check("R7 line64 out", pad_out[64], 1);
        bus_write(16'h0408, 64'h3);  // invert line 1
        check("R7 line1 inverted out", pad_out[1], 0);
        check("R7 line1 inverted oe", pad_oe[1], 1);

        // R9 input with inversion
        pin = {64'hA5A5_0000_FFFF_1234, 64'h0123_4567_89AB_CDEF};
        pad_in = pin;
        bus_read(16'h0000, rd, v);  check("R9 bank0 input", rd, pin[63:0] ^ 64'h2);
        bus_read(16'h1400, rd, v);  check("R9 bank1 input", rd, pin[127:64]);

        // R8 open drain on line 2
        bus_write(16'h0410, 64'h1001);
        check("R8 od low oe", pad_oe[2], 1);
        check("R8 od low out", pad_out[2], 0);
        bus_write(16'h0008, 64'h4);
        check("R8 od release oe", pad_oe[2], 0);
        check("R8 od release out", pad_out[2], 0);

        // R10 function select on line 3
        bus_write(16'h0418, 64'h1);
        bus_write(16'h0008, 64'h8);
        check("R10 pre out", pad_out[3], 1);
        bus_write(16'h0418, 64'h1_0001);
        check("R10 foreign oe", pad_oe[3], 0);
        check("R10 foreign out", pad_out[3], 0);
        bus_write(16'h0010, 64'h8);
        bus_read(16'h0008, rd, v);  check("R10 clear ignored", rd, 64'hE);
        bus_write(16'h0418, 64'h1);
        check("R10 latch kept at pad", pad_out[3], 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule